// File: doc/BRIEF.md
# Multi-Edge Sample Clock Qualifier

This block sits in front of a capture engine. It watches a set of external clock channels and turns them into one sample strobe, one system clock wide. Each clock channel has a 2-bit edge code that turns it off or makes its rising edge, its falling edge or both edges active. Whenever at least one enabled channel shows an active edge, the block raises the strobe. Edges found on several channels in the same system clock cycle give a single strobe.

All inputs are oversampled on a fast system clock through a two-flop synchronizer. An edge is found by comparing a synchronized level with its value one system clock earlier. The data inputs are split into groups. Each group has its own delay of 0 to 3 qualified edges, so that groups with different probe paths can be lined up. The synchronized clock levels are delivered alongside the delayed data, so the capture engine can store them in the same word.

Top module: `clk_edge_qualifier`

## Requirements
- R1: While reset is low, and after it, until the first strobe, `strobe`, `sample_clk` and `sample_data` are all zero. Every delay stage is cleared to zero.
- R2: A clock channel whose code is 00 never causes a strobe, however often it toggles.
- R3: Code 01 (bit 0 of the channel's field) makes a low-to-high change of that channel an active edge.
- R4: Code 10 (bit 1 of the channel's field) makes a high-to-low change an active edge.
- R5: Code 11 makes both directions active.
- R6: An input level change that is present at system clock edge k raises `strobe` at edge k+2 for exactly one cycle. Active edges on several channels in the same cycle give one strobe.
- R7: A group with delay 0 presents, with the strobe, the data sampled together with the clock levels that made the edge.
- R8: A group with delay d from 1 to 3 presents the data captured at the d-th previous strobe. This value is zero if fewer than d strobes have occurred since reset.
- R9: The delay of a group is read when a strobe is formed. A change takes effect on the next strobe and leaves the stored stages intact.
- R10: With every strobe, `sample_clk` carries the synchronized levels of all clock channels at the edge that caused the strobe.
- R11: `sample_clk` and `sample_data` hold their values in cycles without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | Fast oversampling system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_clk_in | input | NUM_CLK (4) | External clock channel levels |
| edge_sel | input | 2*NUM_CLK (8) | Per-channel edge code, channel i in bits [2i+1:2i] |
| grp_data_in | input | NUM_GRP*GRP_W (32) | Data groups, group g in bits [8g+7:8g] |
| grp_delay | input | 2*NUM_GRP (8) | Per-group delay in edges, group g in bits [2g+1:2g] |
| strobe | output | 1 | One-cycle sample strobe |
| sample_clk | output | NUM_CLK (4) | Clock levels of the current sample |
| sample_data | output | NUM_GRP*GRP_W (32) | Delay-aligned data groups |

## Verification
A wrong synchronizer depth or a stale previous-level register shows up as a strobe that comes one cycle early or late, or that is missing or doubled, right at the first edge. The bench compares the strobe on every cycle, so the error is caught there. A wrong tap or a wrong shift in a delay line shows only in the groups with a nonzero delay, and only from the second or later strobe. A stage that is not cleared shows in the first three strobes after reset. For these reasons the delays are exercised right after reset and again after a reset in the middle of the run.

// File: rtl/clk_edge_qualifier.sv
module clk_edge_qualifier #(
  parameter int NUM_CLK   = 4,
  parameter int NUM_GRP   = 4,
  parameter int GRP_W     = 8,
  parameter int DLY_DEPTH = 3,
  localparam int DW   = NUM_GRP * GRP_W,
  localparam int SELW = $clog2(DLY_DEPTH + 1)
) (
  input  logic                    clk_sys,
  input  logic                    rst_n,
  input  logic [NUM_CLK-1:0]      chan_clk_in,
  input  logic [2*NUM_CLK-1:0]    edge_sel,
  input  logic [DW-1:0]           grp_data_in,
  input  logic [SELW*NUM_GRP-1:0] grp_delay,
  output logic                    strobe,
  output logic [NUM_CLK-1:0]      sample_clk,
  output logic [DW-1:0]           sample_data
);

  logic [NUM_CLK-1:0] c_s1, c_s2, c_prev;
  logic [DW-1:0]      d_s1, d_s2;
  logic [NUM_CLK-1:0] hit;
  logic               any_hit;

  always_ff @(posedge clk_sys or negedge rst_n) begin
    if (!rst_n) begin
      c_s1 <= '0; c_s2 <= '0; c_prev <= '0;
      d_s1 <= '0; d_s2 <= '0;
    end else begin
      c_s1 <= chan_clk_in; c_s2 <= c_s1; c_prev <= c_s2;
      d_s1 <= grp_data_in; d_s2 <= d_s1;
    end
  end

  for (genvar i = 0; i < NUM_CLK; i++) begin : g_chan
    assign hit[i] = (edge_sel[2*i]   &  c_s2[i] & ~c_prev[i]) |
                    (edge_sel[2*i+1] & ~c_s2[i] &  c_prev[i]);
  end
  assign any_hit = |hit;

  always_ff @(posedge clk_sys or negedge rst_n) begin
    if (!rst_n) begin
      strobe     <= 1'b0;
      sample_clk <= '0;
    end else begin
      strobe <= any_hit;
      if (any_hit) sample_clk <= c_s2;
    end
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    logic [GRP_W-1:0] stage [DLY_DEPTH];
    logic [GRP_W-1:0] cur, pick;
    logic [SELW-1:0]  sel;

    assign cur = d_s2[g*GRP_W +: GRP_W];
    assign sel = grp_delay[g*SELW +: SELW];

    always_comb begin
      pick = cur;
      for (int k = 1; k <= DLY_DEPTH; k++)
        if (int'(sel) == k || (k == DLY_DEPTH && int'(sel) > DLY_DEPTH))
          pick = stage[k-1];
    end

    always_ff @(posedge clk_sys or negedge rst_n) begin
      if (!rst_n) begin
        for (int k = 0; k < DLY_DEPTH; k++) stage[k] <= '0;
        sample_data[g*GRP_W +: GRP_W] <= '0;
      end else if (any_hit) begin
        stage[0] <= cur;
        for (int k = 1; k < DLY_DEPTH; k++) stage[k] <= stage[k-1];
        sample_data[g*GRP_W +: GRP_W] <= pick;
      end
    end
  end

endmodule

// File: rtl/clk_edge_qualifier_chk.sv
module clk_edge_qualifier_chk #(
  parameter int NUM_CLK = 4,
  parameter int NUM_GRP = 4,
  parameter int GRP_W   = 8,
  parameter int SELW    = 2
) (
  input logic                    clk_sys,
  input logic                    rst_n,
  input logic [NUM_CLK-1:0]      chan_clk_in,
  input logic [2*NUM_CLK-1:0]    edge_sel,
  input logic [NUM_GRP*GRP_W-1:0] grp_data_in,
  input logic [SELW*NUM_GRP-1:0] grp_delay,
  input logic                    strobe,
  input logic [NUM_CLK-1:0]      sample_clk,
  input logic [NUM_GRP*GRP_W-1:0] sample_data
);

  logic [2:0] since;
  always_ff @(posedge clk_sys or negedge rst_n) begin
    if (!rst_n) since <= '0;
    else if (since != 3'd7) since <= since + 3'd1;
  end
  wire warm = (since >= 3'd4);

  always_ff @(posedge clk_sys) begin
    if (!rst_n) begin
      assert_reset_clear_R1: assert (!strobe && sample_clk == '0 && sample_data == '0)
        else $error("outputs not cleared in reset");
    end
  end

  assert_off_no_strobe_R2: assert property (@(posedge clk_sys) disable iff (!rst_n)
    (warm && $past(edge_sel) == '0) |-> !strobe);

  assert_strobe_latency_R6: assert property (@(posedge clk_sys) disable iff (!rst_n)
    (warm && strobe) |-> ($past(chan_clk_in, 3) != $past(chan_clk_in, 4)));

  assert_clk_levels_R10: assert property (@(posedge clk_sys) disable iff (!rst_n)
    (warm && strobe) |-> (sample_clk == $past(chan_clk_in, 3)));

  assert_hold_R11: assert property (@(posedge clk_sys) disable iff (!rst_n)
    !strobe |-> ($stable(sample_clk) && $stable(sample_data)));

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_d0
    assert_delay0_R7: assert property (@(posedge clk_sys) disable iff (!rst_n)
      (warm && strobe && $past(grp_delay[g*SELW +: SELW]) == '0) |->
      (sample_data[g*GRP_W +: GRP_W] == $past(grp_data_in[g*GRP_W +: GRP_W], 3)));
  end

endmodule

bind clk_edge_qualifier clk_edge_qualifier_chk #(
  .NUM_CLK(NUM_CLK), .NUM_GRP(NUM_GRP), .GRP_W(GRP_W), .SELW(SELW)
) u_chk (
  .clk_sys(clk_sys), .rst_n(rst_n), .chan_clk_in(chan_clk_in), .edge_sel(edge_sel),
  .grp_data_in(grp_data_in), .grp_delay(grp_delay), .strobe(strobe),
  .sample_clk(sample_clk), .sample_data(sample_data)
);

// File: tb/sim_clk_edge_qualifier.sv
`timescale 1ns/1ps
module sim_clk_edge_qualifier;
  localparam int NC = 4, NG = 4, GW = 8, DW = NG * GW;

  logic          clk_sys = 1'b0;
  logic          rst_n = 1'b0;
  logic [NC-1:0] chan_clk_in = '0;
  logic [2*NC-1:0] edge_sel = '0;
  logic [DW-1:0] grp_data_in = '0;
  logic [2*NG-1:0] grp_delay = '0;
  logic          strobe;
  logic [NC-1:0] sample_clk;
  logic [DW-1:0] sample_data;

  always #2.5 clk_sys = ~clk_sys;

  clk_edge_qualifier u0 (
    .clk_sys(clk_sys), .rst_n(rst_n), .chan_clk_in(chan_clk_in), .edge_sel(edge_sel),
    .grp_data_in(grp_data_in), .grp_delay(grp_delay), .strobe(strobe),
    .sample_clk(sample_clk), .sample_data(sample_data)
  );

  int checks = 0, fails = 0;
  string tag = "R1";
  bit done = 0;

  // behavioural reference: input history and per-group queue of captured samples
  logic [NC-1:0] hc[$];
  logic [DW-1:0] hd[$];
  logic [GW-1:0] cap [NG][$];
  logic          e_strobe = 0;
  logic [NC-1:0] e_clk = '0;
  logic [DW-1:0] e_data = '0;
  logic [NC-1:0] ma, mb;
  logic [DW-1:0] mbd;
  logic [1:0]    code;
  int            dd;
  bit            mhit;

  always @(posedge clk_sys) begin
    if (!rst_n) begin
      hc.delete(); hd.delete();
      for (int g = 0; g < NG; g++) cap[g].delete();
      e_strobe = 0; e_clk = '0; e_data = '0;
    end else begin
      hc.push_front(chan_clk_in); hd.push_front(grp_data_in);
      if (hc.size() > 4) begin void'(hc.pop_back()); void'(hd.pop_back()); end
      ma  = (hc.size() > 3) ? hc[3] : '0;
      mb  = (hc.size() > 2) ? hc[2] : '0;
      mbd = (hd.size() > 2) ? hd[2] : '0;
      mhit = 0;
      for (int c = 0; c < NC; c++) begin
        code = edge_sel[2*c +: 2];
        if (code[0] && mb[c] && !ma[c]) mhit = 1;
        if (code[1] && !mb[c] && ma[c]) mhit = 1;
      end
      e_strobe = mhit;
      if (mhit) begin
        e_clk = mb;
        for (int g = 0; g < NG; g++) begin
          dd = int'(grp_delay[2*g +: 2]);
          if (dd == 0) e_data[g*GW +: GW] = mbd[g*GW +: GW];
          else e_data[g*GW +: GW] = (cap[g].size() >= dd) ? cap[g][dd-1] : '0;
          cap[g].push_front(mbd[g*GW +: GW]);
          if (cap[g].size() > 3) void'(cap[g].pop_back());
        end
      end
    end
  end

  always @(negedge clk_sys) begin
    if (!done) begin
      checks++;
      if (strobe !== e_strobe) begin
        fails++;
        $display("FAIL %s strobe: actual %b expected %b at %0t", tag, strobe, e_strobe, $time);
      end
      checks++;
      if (sample_clk !== e_clk) begin
        fails++;
        $display("FAIL %s/R10 sample_clk: actual %h expected %h at %0t", tag, sample_clk, e_clk, $time);
      end
      checks++;
      if (sample_data !== e_data) begin
        fails++;
        $display("FAIL %s sample_data: actual %h expected %h at %0t", tag, sample_data, e_data, $time);
      end
    end
  end

  task automatic step(input logic [NC-1:0] c, input logic [DW-1:0] d);
    @(negedge clk_sys); #1;
    chan_clk_in = c; grp_data_in = d;
  endtask

  task automatic run(input int n, input int period, input logic [NC-1:0] tog_mask, input bit rnd_clk);
    logic [NC-1:0] c;
    c = chan_clk_in;
    for (int i = 0; i < n; i++) begin
      if (rnd_clk) c = $urandom;
      else if (i % period == 0) c = c ^ tog_mask;
      step(c, {$urandom, $urandom} );
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(7));
    tag = "R1";                                 // reset state
    repeat (4) @(negedge clk_sys);
    #1 rst_n = 1;
    grp_delay = 8'b11_10_01_00;
    tag = "R8"; edge_sel = 8'b00_00_00_01;      // fill-from-zero, rising on ch0 (R3)
    run(40, 3, 4'b0001, 0);
    tag = "R3"; run(60, 4, 4'b1111, 0);         // ch0 rising, others off and toggling
    tag = "R4"; edge_sel = 8'b00_00_10_00; grp_delay = '0;   // ch1 falling, delay 0 (R7)
    run(60, 3, 4'b0010, 0);
    tag = "R7"; run(40, 5, 4'b1111, 0);
    tag = "R5"; edge_sel = 8'b00_11_00_00;      // ch2 both edges
    run(60, 2, 4'b0100, 0);
    tag = "R2"; edge_sel = '0;                  // all off, heavy toggling
    run(60, 1, 4'b1111, 0);
    tag = "R6"; edge_sel = 8'hFF;               // simultaneous edges merge
    run(60, 3, 4'b1111, 0);
    run(30, 1, 4'b0101, 0);
    tag = "R11"; edge_sel = 8'b01_01_01_01;     // sparse strobes, hold between
    run(80, 9, 4'b0011, 0);
    tag = "R9";                                 // delay changes between strobes
    for (int k = 0; k < 40; k++) begin
      grp_delay = $urandom;
      run(5, 2, 4'b1000, 0);
    end
    tag = "R10"; edge_sel = 8'hFF;
    run(200, 1, 4'b0000, 1);
    tag = "R9";
    for (int k = 0; k < 100; k++) begin
      edge_sel = $urandom; grp_delay = $urandom;
      run(3, 1, 4'b0000, 1);
    end
    tag = "R1";                                 // reset in mid-run, stages cleared
    @(negedge clk_sys); #1 rst_n = 0;
    run(3, 1, 4'b0000, 1);
    @(negedge clk_sys); #1 rst_n = 1;
    tag = "R8"; edge_sel = 8'b00_00_00_11; grp_delay = 8'b11_11_10_01;
    run(60, 2, 4'b0001, 0);
    repeat (4) @(negedge clk_sys);
    finish_run();
  end
endmodule